// File: doc/BRIEF.md
# Byte Memory Control Decoder with Identifier Readout

This block is the control front end of a byte-wide, electrically erasable memory. Each cycle it turns five control inputs into one operating mode: read, output off, standby, program, program verify, erase, erase verify, program blocked, or identifier readout. The inputs are an active-low chip select, an active-low output gate, an active-low program strobe, and two flags that report a raised voltage on the program supply and on address line 9. The data bus is registered. It carries a separate drive enable and a flag that marks when the data is good.

A behavioural array model sits behind the decoder. A program pulse can only clear bits: the new byte is the bitwise AND of the stored byte and the input byte. An erase writes ones into every location, one location per cycle. When the address-9 flag is raised and the program supply is not, the bus carries two fixed identifier bytes, selected by address bit 0. Access delays are modelled as cycle counts. The delay from an address or chip-select change is longer than the delay from the output gate.

Top module: `mtp_mode_front`

## Requirements
- R1: While reset is held and in the cycle after it, `dq_oe`, `dq_valid` and `dq_o` are all 0.
- R2: `dq_oe` is 1 only in the cycle after an edge that sampled `ce_n`=0 and `oe_n`=0; otherwise `dq_oe`=0 and `dq_o`=0. With `ce_n`=1 this holds whatever `oe_n` is.
- R3: With `a9_hv`=1, `vpp_hv`=0, `ce_n`=0 and `oe_n`=0, `dq_o` is `MFG_ID` (default C2h) when `addr[0]`=0 and `DEV_ID` (default D2h) when `addr[0]`=1; the other address bits have no effect.
- R4: In every other case with `ce_n`=0 and `oe_n`=0, `dq_o` is the stored byte at `addr`. This covers a plain read, program verify (`vpp_hv`=1, `pgm_n`=1, `a9_hv`=0) and erase verify (`vpp_hv`=1, `a9_hv`=1, `pgm_n`=1).
- R5: A falling edge of `pgm_n` with `vpp_hv`=1, `ce_n`=0, `oe_n`=1 and `a9_hv`=0 replaces the byte at `addr` with (stored AND `din`), so bits only go from 1 to 0.
- R6: The same `pgm_n` falling edge with `ce_n`=1 leaves the array unchanged.
- R7: Entering the state `vpp_hv`=1, `a9_hv`=1, `ce_n`=0, `oe_n`=1, `pgm_n`=0 sets every byte of the array to all ones within 2^`ADDR_W`+2 cycles.
- R8: A program request that arrives while an erase is sweeping the array is discarded.
- R9: After `addr` or `ce_n` changes while `ce_n`=0 and `oe_n`=0, `dq_valid` is 0 for the first `ACC_CYC`-1 clock edges and 1 after the `ACC_CYC`-th edge, counting the first edge that sees the change.
- R10: After `oe_n` falls while the address and chip select are settled, `dq_valid` becomes 1 after `OE_CYC` edges and is 0 before that (`OE_CYC` < `ACC_CYC`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program strobe, active low |
| a9_hv | input | 1 | Raised voltage present on address line 9 |
| vpp_hv | input | 1 | Program supply at programming level |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Data to program |
| dq_o | output | DATA_W | Data out (0 when not driven) |
| dq_oe | output | 1 | Drive enable for the data bus |
| dq_valid | output | 1 | Data on `dq_o` has met its access delay |

## Verification
An erase sweep and a program strobe can land in the same cycle. Both write through the single port of the array. The bench starts an erase, and a few cycles later, while the sweep is still running, it drops the address-9 flag and pulses the strobe at a location that the sweep has already passed. When the sweep is done, that location must read FFh: an accepted program would have left it at 00h behind the sweep.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
  typedef enum logic [3:0] {
    MD_STANDBY,
    MD_OUT_OFF,
    MD_READ,
    MD_PROGRAM,
    MD_PRG_VERIFY,
    MD_ERASE,
    MD_ERS_VERIFY,
    MD_BLOCKED,
    MD_IDENT
  } mode_e;
endpackage

// File: rtl/mtp_mode_decode.sv
module mtp_mode_decode
  import mtp_pkg::*;
(
  input  logic  ce_n,
  input  logic  oe_n,
  input  logic  pgm_n,
  input  logic  a9_hv,
  input  logic  vpp_hv,
  output mode_e mode,
  output logic  drive
);
  always_comb begin
    if (ce_n) begin
      mode = vpp_hv ? MD_BLOCKED : MD_STANDBY;
    end else if (oe_n) begin
      if (vpp_hv && !pgm_n) mode = a9_hv ? MD_ERASE : MD_PROGRAM;
      else                  mode = MD_OUT_OFF;
    end else if (!vpp_hv) begin
      mode = a9_hv ? MD_IDENT : MD_READ;
    end else if (a9_hv) begin
      mode = MD_ERS_VERIFY;
    end else begin
      mode = pgm_n ? MD_PRG_VERIFY : MD_READ;
    end
    drive = !ce_n && !oe_n;
  end
endmodule

// File: rtl/mtp_access_timer.sv
// Models the access delays: a long count restarted by an address or
// chip-select change, and a short count restarted while the output gate is high.
module mtp_access_timer #(
  parameter int ADDR_W  = 8,
  parameter int ACC_CYC = 6,
  parameter int OE_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  output logic              ready
);
  localparam int CNT_W = $clog2(ACC_CYC + 1);
  localparam logic [CNT_W-1:0] ACC_LIM = CNT_W'(ACC_CYC);
  localparam logic [CNT_W-1:0] OE_LIM  = CNT_W'(OE_CYC);

  logic [ADDR_W-1:0] addr_q;
  logic              ce_q;
  logic [CNT_W-1:0]  acc_q, acc_d, oe_q, oe_d;
  logic              moved;

  always_comb begin
    moved = (addr != addr_q) || (ce_n != ce_q);
    if (moved)                acc_d = CNT_W'(1);
    else if (acc_q < ACC_LIM) acc_d = acc_q + 1'b1;
    else                      acc_d = acc_q;
    if (oe_n)                 oe_d = '0;
    else if (oe_q < OE_LIM)   oe_d = oe_q + 1'b1;
    else                      oe_d = oe_q;
    ready = (acc_d == ACC_LIM) && (oe_d == OE_LIM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      ce_q   <= 1'b1;
      acc_q  <= '0;
      oe_q   <= '0;
    end else begin
      addr_q <= addr;
      ce_q   <= ce_n;
      acc_q  <= acc_d;
      oe_q   <= oe_d;
    end
  end
endmodule

// File: rtl/mtp_cell_array.sv
// Single-port byte array with a clear-only program path (read, then AND-write)
// and an erase engine that writes ones, one location per cycle.
module mtp_cell_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ers_start,
  input  logic              prg_req,
  input  logic [ADDR_W-1:0] prg_addr,
  input  logic [DATA_W-1:0] prg_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ers_busy,
  output logic              prg_pend
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] ptr, cap_addr, ra;
  logic [DATA_W-1:0] cap_data, rd_q;
  logic              pend, wr, kill;

  assign kill     = ers_start || ers_busy;
  assign ra       = pend ? cap_addr : rd_addr;
  assign rd_data  = rd_q;
  assign prg_pend = pend || wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ers_busy <= 1'b0;
      ptr      <= '0;
      pend     <= 1'b0;
      wr       <= 1'b0;
    end else begin
      if (ers_start && !ers_busy) begin
        ers_busy <= 1'b1;
        ptr      <= '0;
      end else if (ers_busy) begin
        ptr <= ptr + 1'b1;
        if (ptr == LAST) ers_busy <= 1'b0;
      end
      pend <= prg_req && !kill;
      wr   <= pend && !kill;
    end
  end

  always_ff @(posedge clk) begin
    if (prg_req && !kill) begin
      cap_addr <= prg_addr;
      cap_data <= prg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (ers_busy)  mem[ptr]      <= '1;
    else if (wr)   mem[cap_addr] <= rd_q & cap_data;
    rd_q <= mem[ra];
  end
endmodule

// File: rtl/mtp_mode_front.sv
module mtp_mode_front
  import mtp_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int ACC_CYC = 6,   // must be >= 2 and greater than OE_CYC
  parameter int OE_CYC  = 3,   // must be >= 2
  parameter logic [DATA_W-1:0] MFG_ID = DATA_W'(8'hC2),
  parameter logic [DATA_W-1:0] DEV_ID = DATA_W'(8'hD2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              a9_hv,
  input  logic              vpp_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              dq_valid
);
  mode_e             mode;
  logic              drive, ready, ers_busy, prg_pend;
  logic              pgm_q, ers_q, prg_req, ers_start;
  logic [DATA_W-1:0] rd_data, sel;

  mtp_mode_decode u_dec (
    .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n), .a9_hv(a9_hv),
    .vpp_hv(vpp_hv), .mode(mode), .drive(drive)
  );

  mtp_access_timer #(.ADDR_W(ADDR_W), .ACC_CYC(ACC_CYC), .OE_CYC(OE_CYC)) u_tmr (
    .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .oe_n(oe_n), .ready(ready)
  );

  assign prg_req   = (mode == MD_PROGRAM) && pgm_q;
  assign ers_start = (mode == MD_ERASE) && !ers_q;

  mtp_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .rst(rst), .ers_start(ers_start), .prg_req(prg_req),
    .prg_addr(addr), .prg_data(din), .rd_addr(addr), .rd_data(rd_data),
    .ers_busy(ers_busy), .prg_pend(prg_pend)
  );

  assign sel = (mode == MD_IDENT) ? (addr[0] ? DEV_ID : MFG_ID) : rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_o     <= '0;
      dq_oe    <= 1'b0;
      dq_valid <= 1'b0;
      pgm_q    <= 1'b1;
      ers_q    <= 1'b0;
    end else begin
      dq_o     <= drive ? sel : '0;
      dq_oe    <= drive;
      dq_valid <= drive && ready;
      pgm_q    <= pgm_n;
      ers_q    <= (mode == MD_ERASE);
    end
  end
endmodule

// File: rtl/mtp_front_chk.sv
module mtp_front_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] MFG_ID = DATA_W'(8'hC2),
  parameter logic [DATA_W-1:0] DEV_ID = DATA_W'(8'hD2)
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_n,
  input logic              oe_n,
  input logic              a9_hv,
  input logic              vpp_hv,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_oe,
  input logic              dq_valid,
  input logic              ers_busy,
  input logic              prg_pend
);
  p_hiz_ce_r2: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> (!dq_oe && dq_o == '0));
  p_hiz_oe_r2: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> !dq_oe);
  p_mfg_r3: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !oe_n && a9_hv && !vpp_hv && !addr[0]) |=> (dq_o == MFG_ID));
  p_dev_r3: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !oe_n && a9_hv && !vpp_hv && addr[0]) |=> (dq_o == DEV_ID));
  p_erase_wins_r8: assert property (@(posedge clk) disable iff (rst)
    ers_busy |-> !prg_pend);
  p_acc_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (addr != $past(addr)) |=> !dq_valid);
  p_oe_delay_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_n) |=> !dq_valid);
  p_valid_driven_r10: assert property (@(posedge clk) disable iff (rst)
    dq_valid |-> dq_oe);
endmodule

bind mtp_mode_front mtp_front_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MFG_ID(MFG_ID), .DEV_ID(DEV_ID)
) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .a9_hv(a9_hv),
  .vpp_hv(vpp_hv), .addr(addr), .dq_o(dq_o), .dq_oe(dq_oe),
  .dq_valid(dq_valid), .ers_busy(ers_busy), .prg_pend(prg_pend)
);

// File: tb/sim_mtp_mode_front.sv
module sim_mtp_mode_front;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int ACC_CYC = 6;
  localparam int OE_CYC  = 3;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int NVEC    = 12;

  // {req[3:0], ce_n, oe_n, pgm_n, a9_hv, vpp_hv, addr[7:0], exp_oe, exp_data[7:0]}
  localparam logic [25:0] VT [NVEC] = '{
    {4'd5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd5,   1'b1, 8'h24}, // R5 A5 AND 3C
    {4'd4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd5,   1'b1, 8'h24}, // R4 program verify
    {4'd4, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd12,  1'b1, 8'h81}, // R4 erase verify
    {4'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd0,   1'b1, 8'hC2}, // R3 maker byte
    {4'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd1,   1'b1, 8'hD2}, // R3 device byte
    {4'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFE,  1'b1, 8'hC2}, // R3 upper bits ignored
    {4'd6, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd9,   1'b1, 8'hFF}, // R6 blocked program
    {4'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd5,   1'b0, 8'h00}, // R2 standby
    {4'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd5,   1'b0, 8'h00}, // R2 output off
    {4'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'd5,   1'b0, 8'h00}, // R2 blocked state
    {4'd7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd200, 1'b1, 8'hFF}, // R7 erased byte
    {4'd4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd12,  1'b1, 8'h81}  // R4 plain read
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, a9_hv = 1'b0, vpp_hv = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dq_o;
  logic              dq_oe, dq_valid;
  int                n_cmp = 0;
  int                n_bad = 0;

  always #2 clk = ~clk;

  mtp_mode_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_CYC(ACC_CYC), .OE_CYC(OE_CYC)) u0 (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n), .a9_hv(a9_hv),
    .vpp_hv(vpp_hv), .addr(addr), .din(din), .dq_o(dq_o), .dq_oe(dq_oe), .dq_valid(dq_valid)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic set_ctl(input logic c, input logic o, input logic p, input logic a9, input logic vp);
    ce_n = c; oe_n = o; pgm_n = p; a9_hv = a9; vpp_hv = vp;
  endtask

  task automatic program_byte(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input logic c);
    addr = a; din = d;
    set_ctl(c, 1'b1, 1'b1, 1'b0, 1'b1);
    step(2);
    pgm_n = 1'b0;
    step(4);
    pgm_n = 1'b1;
    step(2);
    set_ctl(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    step(1);
  endtask

  task automatic erase_all();
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    step(2);
    pgm_n = 1'b0;
    step(DEPTH + 4);
    set_ctl(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    step(2);
  endtask

  task automatic read_chk(input string tag, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e);
    addr = a;
    set_ctl(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    step(ACC_CYC + 2);
    chk({tag, " valid"}, 32'(dq_valid), 32'd1);
    chk({tag, " data"}, 32'(dq_o), 32'(e));
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    step(3);
    // R1: outputs quiet in reset and in the cycle after it
    chk("R1 oe in reset", 32'(dq_oe), 32'd0);
    chk("R1 valid in reset", 32'(dq_valid), 32'd0);
    rst = 1'b0;
    step(1);
    chk("R1 data after reset", 32'(dq_o), 32'd0);
    chk("R1 oe after reset", 32'(dq_oe), 32'd0);

    erase_all();
    program_byte(8'd5, 8'hA5, 1'b0);
    program_byte(8'd5, 8'h3C, 1'b0);
    program_byte(8'd9, 8'h00, 1'b1);
    program_byte(8'd12, 8'h81, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      logic [25:0] v;
      string       tag;
      v = VT[i];
      tag = $sformatf("R%0d vec%0d", v[25:22], i);
      set_ctl(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      step(2);
      addr = v[16:9];
      set_ctl(v[21], v[20], v[19], v[18], v[17]);
      step(ACC_CYC + 2);
      chk({tag, " oe"}, 32'(dq_oe), 32'(v[8]));
      chk({tag, " data"}, 32'(dq_o), 32'(v[7:0]));
      if (v[8]) chk({tag, " valid"}, 32'(dq_valid), 32'd1);
    end

    // R9: address change restarts the long access count
    read_chk("R9 setup", 8'd12, 8'h81);
    addr = 8'd5;
    step(ACC_CYC - 1);
    chk("R9 valid early", 32'(dq_valid), 32'd0);
    step(1);
    chk("R9 valid on time", 32'(dq_valid), 32'd1);
    chk("R9 data", 32'(dq_o), 32'h24);

    // R10: output gate delay is the short count
    oe_n = 1'b1;
    step(4);
    oe_n = 1'b0;
    step(OE_CYC - 1);
    chk("R10 valid early", 32'(dq_valid), 32'd0);
    step(1);
    chk("R10 valid on time", 32'(dq_valid), 32'd1);
    chk("R10 data", 32'(dq_o), 32'h24);

    // R8: program strobe during an erase sweep is discarded
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    step(2);
    pgm_n = 1'b0;
    step(2);
    addr = 8'd2; din = 8'h00;
    set_ctl(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    step(2);
    pgm_n = 1'b0;
    step(3);
    pgm_n = 1'b1;
    step(DEPTH + 4);
    set_ctl(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    step(2);
    read_chk("R8 dropped program", 8'd2, 8'hFF);
    read_chk("R7 erased addr5", 8'd5, 8'hFF);
    read_chk("R7 erased addr12", 8'd12, 8'hFF);

    // R5: programming works again once the sweep is done
    program_byte(8'd2, 8'h5A, 1'b0);
    read_chk("R5 program after erase", 8'd2, 8'h5A);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule